// File: doc/BRIEF.md
# Capability Fault Indicator Latch

This block turns capability-violation exceptions into lasting visual indicators. Each time the processor reports such an exception, it supplies a valid strobe and a numeric exception code. The block sets the indicator bit whose position equals that code, and the bit stays set after the handler has returned. A latched bit is cleared only by a software write.

Software reaches the block through one machine-mode control register at CSR address 0xBC0. A write loads the latch directly. Writing zero clears every indicator and gives control back to hardware. Bit 0 of the register is an override flag. While it is set, hardware capture is frozen and the written bits drive the indicator outputs directly. A read of the register returns the live latch contents, including the override flag.

The indicator output is the latch itself. It is meant to feed board LEDs, one per exception kind.

Top module: `capfault_led_latch`

## Requirements
- R1: After reset, `led_o` is 0 and a read of CSR 0xBC0 returns 0.
- R2: With the override flag (bit 0) clear, a strobe with code c sets `led_o[c]` on the next clock edge. This holds for c in {1, 2, 3, 17, 18, 19, 21, 22, 24}. No other bit of `led_o` is ever 1 except bit 0, so `led_o & ~32'h016E000F` is always 0.
- R3: A latched bit stays 1 on every later cycle, with or without further strobes, until a CSR write to 0xBC0 changes it.
- R4: A strobe whose code is not in the set of R2 leaves `led_o` unchanged. This covers 0, 4 to 16, 20, 23 and 25 to 31.
- R5: A write to CSR 0xBC0 loads `csr_wdata_i & 32'h016E000F` into the latch on the next edge. Writing 0 clears every indicator.
- R6: While bit 0 of the latch is 1, strobes have no effect. `led_o` then holds exactly the last written value.
- R7: If a strobe and a CSR write to 0xBC0 arrive in the same cycle, the written value is loaded first and the strobe's bit is then ORed in. The strobe is dropped if the written value has bit 0 set.
- R8: When `csr_en_i` is high and `csr_addr_i` is 0xBC0, `csr_rdata_o` equals `led_o` in the same cycle. At any other address `csr_rdata_o` is 0, and writes there leave the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | Exception report strobe, one cycle per exception |
| exc_code_i | input | 5 | Exception code accompanying the strobe |
| csr_en_i | input | 1 | CSR access in this cycle |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data, combinational |
| led_o | output | 32 | Latched indicator vector, bit index equals exception code |

## Verification
The assertions assume the strobe and the CSR port carry known values whenever reset is released. They also assume any write is a single-cycle pulse whose data is stable in that cycle. The stimulus meets this by changing every input only on the falling clock edge, one operation per cycle. It returns the CSR enable to zero between accesses, and it sends codes across the whole 5-bit range, both mapped and unmapped. Same-cycle strobe and write collisions are driven on purpose, with the override flag both set and clear, because that ordering is the subtle rule.

// File: rtl/capled_pkg.sv
package capled_pkg;

    localparam int unsigned NUM_CAP_CODES = 9;

    // Exception codes that own an indicator bit (bit index equals code).
    localparam int unsigned CAP_CODES [NUM_CAP_CODES] = '{1, 2, 3, 17, 18, 19, 21, 22, 24};

    localparam int unsigned OVERRIDE_BIT = 0;

    function automatic logic [63:0] cap_code_mask();
        logic [63:0] m;
        m = '0;
        for (int k = 0; k < int'(NUM_CAP_CODES); k++) begin
            m[CAP_CODES[k]] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] csr_write_mask();
        logic [63:0] m;
        m = cap_code_mask();
        m[OVERRIDE_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/capled_code_decode.sv
module capled_code_decode #(
    parameter int unsigned CODE_W = 5,
    parameter int unsigned DATA_W = 32
) (
    input  logic              valid_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [DATA_W-1:0] set_vec_o
);
    localparam logic [63:0] CODE_MASK = capled_pkg::cap_code_mask();

    for (genvar i = 0; i < int'(DATA_W); i++) begin : g_bit
        if (i != int'(capled_pkg::OVERRIDE_BIT) && CODE_MASK[i]) begin : g_mapped
            localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
            assign set_vec_o[i] = valid_i && (code_i == IDX);
        end else begin : g_unmapped
            assign set_vec_o[i] = 1'b0;
        end
    end
endmodule

// File: rtl/capled_csr_port.sv
module capled_csr_port #(
    parameter int unsigned          ADDR_W   = 12,
    parameter int unsigned          DATA_W   = 32,
    parameter logic [ADDR_W-1:0]    CSR_ADDR = 12'hBC0
) (
    input  logic              en_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] latch_i,
    output logic              wr_hit_o,
    output logic [DATA_W-1:0] wr_val_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [DATA_W-1:0] WR_MASK = DATA_W'(capled_pkg::csr_write_mask());

    logic sel;

    always_comb begin
        sel      = en_i && (addr_i == CSR_ADDR);
        wr_hit_o = sel && we_i;
        wr_val_o = wdata_i & WR_MASK;
        rdata_o  = sel ? latch_i : '0;
    end
endmodule

// File: rtl/capled_latch.sv
module capled_latch #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_hit_i,
    input  logic [DATA_W-1:0] wr_val_i,
    input  logic [DATA_W-1:0] set_vec_i,
    output logic [DATA_W-1:0] latch_o
);
    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } latch_state_t;

    latch_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Software load takes effect first.
        if (wr_hit_i) begin
            state_d.bits = wr_val_i;
        end
        // Hardware capture only while the override flag is clear.
        if (!state_d.bits[capled_pkg::OVERRIDE_BIT]) begin
            state_d.bits = state_d.bits | set_vec_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign latch_o = state_q.bits;
endmodule

// File: rtl/capfault_led_latch.sv
module capfault_led_latch #(
    parameter int unsigned       CODE_W   = 5,
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'hBC0
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic              csr_en_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [DATA_W-1:0] csr_wdata_i,
    output logic [DATA_W-1:0] csr_rdata_o,
    output logic [DATA_W-1:0] led_o
);
    logic [DATA_W-1:0] set_vec;
    logic              wr_hit;
    logic [DATA_W-1:0] wr_val;
    logic [DATA_W-1:0] latch;

    capled_code_decode #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W)
    ) u_decode (
        .valid_i   (exc_valid_i),
        .code_i    (exc_code_i),
        .set_vec_o (set_vec)
    );

    capled_csr_port #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CSR_ADDR (CSR_ADDR)
    ) u_csr (
        .en_i     (csr_en_i),
        .we_i     (csr_we_i),
        .addr_i   (csr_addr_i),
        .wdata_i  (csr_wdata_i),
        .latch_i  (latch),
        .wr_hit_o (wr_hit),
        .wr_val_o (wr_val),
        .rdata_o  (csr_rdata_o)
    );

    capled_latch #(
        .DATA_W (DATA_W)
    ) u_latch (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_hit_i  (wr_hit),
        .wr_val_i  (wr_val),
        .set_vec_i (set_vec),
        .latch_o   (latch)
    );

    assign led_o = latch;
endmodule

// File: rtl/capled_checker.sv
module capled_checker #(
    parameter int unsigned       CODE_W   = 5,
    parameter int unsigned       ADDR_W   = 12,
    parameter int unsigned       DATA_W   = 32,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'hBC0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              exc_valid_i,
    input logic [CODE_W-1:0] exc_code_i,
    input logic              csr_en_i,
    input logic              csr_we_i,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [DATA_W-1:0] csr_wdata_i,
    input logic [DATA_W-1:0] csr_rdata_o,
    input logic [DATA_W-1:0] led_o
);
    localparam logic [DATA_W-1:0] WMASK = DATA_W'(capled_pkg::csr_write_mask());
    localparam logic [63:0]       CMASK = capled_pkg::cap_code_mask();

    logic wr_hit;
    logic code_known;
    assign wr_hit     = csr_en_i && csr_we_i && (csr_addr_i == CSR_ADDR);
    assign code_known = CMASK[exc_code_i];

    AST_ONLY_MAPPED_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (led_o & ~WMASK) == '0);  // R2

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_hit |=> ((led_o & $past(led_o)) == $past(led_o)));  // R3

    AST_UNKNOWN_CODE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (exc_valid_i && !code_known && !wr_hit) |=> $stable(led_o));  // R4

    AST_WRITE_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_hit && !exc_valid_i) |=> (led_o == $past(csr_wdata_i & WMASK)));  // R5

    AST_OVERRIDE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (led_o[0] && !wr_hit) |=> $stable(led_o));  // R6

    AST_READ_MIRRORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_en_i && csr_addr_i == CSR_ADDR) |-> (csr_rdata_o == led_o));  // R8
endmodule

bind capfault_led_latch capled_checker #(
    .CODE_W   (CODE_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CSR_ADDR (CSR_ADDR)
) u_capled_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .csr_en_i    (csr_en_i),
    .csr_we_i    (csr_we_i),
    .csr_addr_i  (csr_addr_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .led_o       (led_o)
);

// File: tb/capfault_led_latch_test.sv
module capfault_led_latch_test;

    localparam logic [31:0] MASK = 32'h016E_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [4:0]  exc_code = '0;
    logic        csr_en = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic [31:0] led;

    int checks = 0;
    int errors = 0;
    logic [31:0] model = '0;
    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    capfault_led_latch uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .exc_valid_i (exc_valid),
        .exc_code_i  (exc_code),
        .csr_en_i    (csr_en),
        .csr_we_i    (csr_we),
        .csr_addr_i  (csr_addr),
        .csr_wdata_i (csr_wdata),
        .csr_rdata_o (csr_rdata),
        .led_o       (led)
    );

    function automatic bit mapped(input logic [4:0] c);
        return (c != 5'd0) && MASK[c];
    endfunction

    // Driver: one cycle of stimulus, updates the reference, pushes expectation.
    task automatic cyc(input bit ev, input logic [4:0] code, input bit wr,
                       input logic [11:0] addr, input logic [31:0] wd, input string tag);
        @(negedge clk);
        exc_valid = ev; exc_code = code;
        csr_en = wr; csr_we = wr; csr_addr = addr; csr_wdata = wd;
        @(posedge clk);
        if (wr && addr == 12'hBC0) model = wd & MASK;
        if (ev && mapped(code) && !model[0]) model[code] = 1'b1;
        exp_q.push_back(model);
        tag_q.push_back(tag);
        #1;
        exc_valid = 1'b0; csr_en = 1'b0; csr_we = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        csr_en = 1'b1; csr_we = 1'b0; csr_addr = addr;
        #1;
        checks++;
        if (csr_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata actual %h expected %h", tag, csr_rdata, exp);
        end
        csr_en = 1'b0;
    endtask

    // Monitor: compare registered output against queued expectations.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (led !== e) begin
                errors++;
                $display("FAIL %s: led actual %h expected %h", t, led, e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (led !== 32'h0) begin
            errors++;
            $display("FAIL R1: led actual %h expected %h", led, 32'h0);
        end
        rst_n = 1'b1;
        read_chk(12'hBC0, 32'h0, "R1");

        // R2: every mapped code sets its bit; R3: earlier bits stay.
        cyc(1, 5'd1, 0, 12'h0, 32'h0, "R2");
        cyc(1, 5'd24, 0, 12'h0, 32'h0, "R2");
        cyc(1, 5'd18, 0, 12'h0, 32'h0, "R2");
        cyc(0, 5'd0, 0, 12'h0, 32'h0, "R3");
        cyc(1, 5'd1, 0, 12'h0, 32'h0, "R3");
        read_chk(12'hBC0, 32'h0104_0002, "R8");

        // R4: unmapped codes, including 0 (override bit), leave led alone.
        for (int c = 0; c < 32; c++) begin
            if (!mapped(5'(c))) cyc(1, 5'(c), 0, 12'h0, 32'h0, "R4");
        end

        // R2 remaining mapped codes.
        for (int c = 1; c < 32; c++) begin
            if (mapped(5'(c))) cyc(1, 5'(c), 0, 12'h0, 32'h0, "R2");
        end
        read_chk(12'hBC0, 32'h016E_000E, "R2");

        // R8: other address reads 0, writes elsewhere ignored.
        read_chk(12'hBC1, 32'h0, "R8");
        cyc(0, 5'd0, 1, 12'h3C0, 32'h0, "R8");

        // R5: write loads masked value, write 0 clears.
        cyc(0, 5'd0, 1, 12'hBC0, 32'hFFFF_FFF6, "R5");
        cyc(0, 5'd0, 1, 12'hBC0, 32'h0, "R5");

        // R6: override flag freezes capture, led follows written bits.
        cyc(0, 5'd0, 1, 12'hBC0, 32'h0022_0009, "R6");
        cyc(1, 5'd2, 0, 12'h0, 32'h0, "R6");
        cyc(1, 5'd17, 0, 12'h0, 32'h0, "R6");
        read_chk(12'hBC0, 32'h0022_0009, "R6");

        // R7: collisions.
        cyc(1, 5'd3, 1, 12'hBC0, 32'h0008_0000, "R7");
        cyc(1, 5'd22, 1, 12'hBC0, 32'h0000_0003, "R7");
        cyc(1, 5'd21, 1, 12'hBC0, 32'h0, "R7");
        cyc(1, 5'd4, 1, 12'hBC0, 32'h0100_0000, "R7");

        // R3: long hold without writes.
        for (int k = 0; k < 20; k++) cyc(0, 5'd0, 0, 12'h0, 32'h0, "R3");

        // R1: reset clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        model = '0;
        #1;
        checks++;
        if (led !== 32'h0) begin
            errors++;
            $display("FAIL R1: led actual %h expected %h", led, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        read_chk(12'hBC0, 32'h0, "R1");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule